// File: doc/BRIEF.md
# Synchronous Quadrature Position Decoder

This block turns the two phase outputs of an incremental shaft encoder into a signed position count. All of its work is done in the single system clock domain. The phase inputs and the index input are never used as clocks. Each of them passes through a multi-flop synchroniser. The system clock must run much faster than the fastest genuine phase transition.

A two-bit phase register stays locked to the last accepted phase pair. On every clock, a sixteen-entry table indexed by that register and the freshly sampled pair decides three things: whether to count, in which direction, and whether the move was illegal. An illegal move is one where both phases changed between two samples. Every edge of either phase counts, so a full quadrature cycle gives four counts. Contact chatter on one phase produces matching up and down counts, so the position comes out right once the input settles.

The first index pulse after reset zeroes the position. Later index pulses have no effect. Illegal moves set a sticky error flag, which stays set until software-independent logic pulses a clear input.

Top module: `qdec_top`

## Requirements
- R1: A change on the phase or index inputs affects the outputs on the third rising clock edge after the change, and not earlier.
- R2: With the phase pair written {A,B}, the sequence 00, 10, 11, 01, 00 is the up direction. Each such step adds one to `pos_o` and raises `step_o` for exactly one cycle, with `dir_o` = 1.
- R3: The reverse order 00, 01, 11, 10, 00 subtracts one per step and raises `step_o` for one cycle, with `dir_o` = 0.
- R4: When both phases change between two samples, `pos_o` keeps its value, `step_o` stays low and `err_o` is set. Tracking then relocks to the new pair, so the next single-phase step counts normally.
- R5: `err_o` stays set until `err_clr_i` is high at a rising edge, and is low after that edge.
- R6: One phase toggling back and forth produces alternating +1 and −1 steps, leaving the position where it started.
- R7: The first rising edge of the index input after reset clears `pos_o` to zero. Every later index edge leaves `pos_o` unchanged.
- R8: After reset, `pos_o` = 0, `err_o` = 0 and `step_o` = 0. Phase inputs already at a non-zero level when reset is released cause no count and no error.
- R9: `pos_o` wraps in two's complement: one up step from the largest positive value gives the most negative value, and one down step from there returns to the largest positive value.
- R10: While the sampled phase pair does not change, `step_o` stays low and `pos_o` holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| enc_a_i | input | 1 | Encoder phase A (asynchronous) |
| enc_b_i | input | 1 | Encoder phase B (asynchronous) |
| enc_idx_i | input | 1 | Encoder index pulse (asynchronous) |
| err_clr_i | input | 1 | Clears the sticky error flag |
| pos_o | output | POS_W | Signed position count |
| err_o | output | 1 | Sticky illegal-transition flag |
| step_o | output | 1 | One-cycle strobe per counted edge |
| dir_o | output | 1 | Direction of the last step, 1 = up |

## Verification
Two synchroniser flops and the registered count stage sit on the path, so a phase or index change is due on `pos_o`, `step_o` and `err_o` just after the third rising edge. The step strobe falls again after the fourth edge. The clear input acts on the first edge.

The bench drives every input just after a falling edge and counts exactly three rising edges before it samples. It then samples one edge later to confirm the strobe has dropped. A dedicated check samples after two edges to show that nothing has moved yet.

// File: rtl/qdec_pkg.sv
package qdec_pkg;

    localparam int PHASE_BITS = 2;
    localparam int TABLE_N    = 1 << (2 * PHASE_BITS);

    // phase pair packed as {A, B}
    typedef logic [PHASE_BITS-1:0] phase_t;

    typedef struct packed {
        logic   en;
        logic   up;
        logic   err;
        phase_t nxt;
    } step_t;

    // next pair in the counting-up order 00 -> 10 -> 11 -> 01 -> 00
    function automatic phase_t up_of(phase_t p);
        phase_t r;
        case (p)
            2'b00:   r = 2'b10;
            2'b10:   r = 2'b11;
            2'b11:   r = 2'b01;
            default: r = 2'b00;
        endcase
        return r;
    endfunction

    // one table entry: present tracked pair versus sampled pair
    function automatic step_t decode(phase_t cur, phase_t smp);
        step_t r;
        r.en  = 1'b0;
        r.up  = 1'b0;
        r.err = 1'b0;
        r.nxt = smp;
        case (cur ^ smp)
            2'b00: r.nxt = cur;
            2'b11: r.err = 1'b1;
            default: begin
                r.en = 1'b1;
                r.up = (smp == up_of(cur));
            end
        endcase
        return r;
    endfunction

endpackage

// File: rtl/qdec_sync.sv
module qdec_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            for (int k = 0; k < STAGES; k++) stage_q[k] <= '0;
        end else begin
            stage_q[0] <= d_i;
            for (int k = 1; k < STAGES; k++) stage_q[k] <= stage_q[k-1];
        end
    end

    assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/qdec_phase_engine.sv
module qdec_phase_engine
    import qdec_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic   clk_i,
    input  logic   rst_i,
    input  phase_t smp_i,
    output step_t  step_o,
    output logic   active_o
);

    // the synchroniser holds reset values for SYNC_STAGES edges;
    // keep loading the tracker until genuine samples have arrived
    localparam int WARM = SYNC_STAGES + 1;
    localparam int WW   = $clog2(WARM + 1);

    logic [WW-1:0] warm_q;
    phase_t        phase_q;
    step_t         lut [TABLE_N];
    step_t         hit;
    logic          active;

    for (genvar i = 0; i < TABLE_N; i++) begin : g_lut
        assign lut[i] = decode(phase_t'(i / 4), phase_t'(i % 4));
    end

    assign active   = (warm_q == WW'(WARM));
    assign hit      = lut[{phase_q, smp_i}];
    assign step_o   = active ? hit : '0;
    assign active_o = active;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            warm_q  <= '0;
            phase_q <= '0;
        end else if (!active) begin
            warm_q  <= warm_q + WW'(1);
            phase_q <= smp_i;
        end else begin
            phase_q <= hit.nxt;
        end
    end

    // R10
    hold_quiet_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (active && smp_i == phase_q) |-> (!step_o.en && !step_o.err));

    // R4
    jump_relock_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (active && step_o.err) |=> (phase_q == $past(smp_i)));

endmodule

// File: rtl/qdec_position.sv
module qdec_position #(
    parameter int W = 16
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic         en_i,
    input  logic         up_i,
    input  logic         clr_i,
    output logic [W-1:0] pos_o
);

    logic [W-1:0] pos_q;

    always_ff @(posedge clk_i) begin
        if (rst_i || clr_i) begin
            pos_q <= '0;
        end else if (en_i) begin
            pos_q <= up_i ? pos_q + W'(1) : pos_q - W'(1);
        end
    end

    assign pos_o = pos_q;

    // R2
    pos_up_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (en_i && up_i && !clr_i) |=> (pos_q == $past(pos_q) + W'(1)));

    // R3
    pos_down_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (en_i && !up_i && !clr_i) |=> (pos_q == $past(pos_q) - W'(1)));

    // R7
    pos_clear_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        clr_i |=> (pos_q == '0));

    // R10
    pos_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (!en_i && !clr_i) |=> $stable(pos_q));

endmodule

// File: rtl/qdec_top.sv
module qdec_top
    import qdec_pkg::*;
#(
    parameter int POS_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                    clk_i,
    input  logic                    rst_i,
    input  logic                    enc_a_i,
    input  logic                    enc_b_i,
    input  logic                    enc_idx_i,
    input  logic                    err_clr_i,
    output logic signed [POS_W-1:0] pos_o,
    output logic                    err_o,
    output logic                    step_o,
    output logic                    dir_o
);

    logic [2:0]       raw;
    logic [2:0]       synced;
    phase_t           smp;
    step_t            step;
    logic             active;
    logic             idx_prev_q;
    logic             armed_q;
    logic             idx_clr;
    logic             err_q;
    logic             step_q;
    logic             dir_q;
    logic [POS_W-1:0] pos;

    assign raw = {enc_a_i, enc_b_i, enc_idx_i};

    qdec_sync #(
        .WIDTH (3),
        .STAGES(SYNC_STAGES)
    ) i_sync (
        .clk_i(clk_i),
        .rst_i(rst_i),
        .d_i  (raw),
        .q_o  (synced)
    );

    assign smp = synced[2:1];

    qdec_phase_engine #(
        .SYNC_STAGES(SYNC_STAGES)
    ) i_engine (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .smp_i   (smp),
        .step_o  (step),
        .active_o(active)
    );

    assign idx_clr = active && armed_q && synced[0] && !idx_prev_q;

    qdec_position #(
        .W(POS_W)
    ) i_pos (
        .clk_i(clk_i),
        .rst_i(rst_i),
        .en_i (step.en),
        .up_i (step.up),
        .clr_i(idx_clr),
        .pos_o(pos)
    );

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            idx_prev_q <= 1'b0;
            armed_q    <= 1'b1;
            err_q      <= 1'b0;
            step_q     <= 1'b0;
            dir_q      <= 1'b0;
        end else begin
            idx_prev_q <= synced[0];
            if (idx_clr) armed_q <= 1'b0;
            if (step.err)       err_q <= 1'b1;
            else if (err_clr_i) err_q <= 1'b0;
            step_q <= step.en;
            if (step.en) dir_q <= step.up;
        end
    end

    assign pos_o  = pos;
    assign err_o  = err_q;
    assign step_o = step_q;
    assign dir_o  = dir_q;

    // R5
    err_sticky_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (err_q && !err_clr_i) |=> err_q);

    // R5
    err_clear_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (err_clr_i && !step.err) |=> !err_q);

    // R7
    index_once_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !armed_q |=> !armed_q);

    // R4
    err_no_step_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(err_q) |-> !step_q);

endmodule

// File: tb/test_qdec_top.sv
`timescale 1ns/1ps
module test_qdec_top;

    localparam int W = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic a = 1'b0, b = 1'b0, idx = 1'b0, eclr = 1'b0;
    logic signed [W-1:0] pos;
    logic err, stp, dir;

    int total = 0;
    int fails = 0;
    logic [W-1:0] ref_pos;
    logic [1:0]   cur_ab;

    always #10 clk = ~clk;

    qdec_top #(.POS_W(W), .SYNC_STAGES(2)) i_qdec_top (
        .clk_i(clk), .rst_i(rst), .enc_a_i(a), .enc_b_i(b),
        .enc_idx_i(idx), .err_clr_i(eclr),
        .pos_o(pos), .err_o(err), .step_o(stp), .dir_o(dir)
    );

    // entry: {A, B, expect step, expect dir, expect err level}
    localparam logic [4:0] VEC [17] = '{
        5'b10_1_1_0, 5'b11_1_1_0, 5'b01_1_1_0, 5'b00_1_1_0,   // R2 up
        5'b01_1_0_0, 5'b11_1_0_0, 5'b10_1_0_0, 5'b00_1_0_0,   // R3 down
        5'b10_1_1_0, 5'b00_1_0_0, 5'b10_1_1_0, 5'b00_1_0_0,   // R6 chatter
        5'b11_0_0_1, 5'b01_1_1_1, 5'b10_0_0_1, 5'b00_1_0_1,   // R4 jumps
        5'b00_0_0_1                                           // R10 hold
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic [1:0] ab);
        @(negedge clk);
        rst = 1'b1; {a, b} = ab; idx = 1'b0; eclr = 1'b0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        repeat (8) @(posedge clk);
        #2;
        ref_pos = '0;
        cur_ab  = ab;
    endtask

    // drive a pair, sample after the third edge, then check the strobe drops
    task automatic drive(input logic [1:0] ab, input string req,
                         input logic e_step, input logic e_dir);
        @(negedge clk);
        {a, b} = ab;
        repeat (3) @(posedge clk);
        #2;
        chk(req, {31'b0, stp}, {31'b0, e_step});
        if (e_step) chk(req, {31'b0, dir}, {31'b0, e_dir});
        chk(req, {24'b0, pos}, {24'b0, ref_pos});
        @(posedge clk);
        #2;
        chk(req, {31'b0, stp}, 32'd0);
        cur_ab = ab;
    endtask

    function automatic logic [1:0] up_next(input logic [1:0] p);
        case (p)
            2'b00:   return 2'b10;
            2'b10:   return 2'b11;
            2'b11:   return 2'b01;
            default: return 2'b00;
        endcase
    endfunction

    task automatic step_up(input string req);
        ref_pos = ref_pos + 1'b1;
        drive(up_next(cur_ab), req, 1'b1, 1'b1);
    endtask

    task automatic pulse_index();
        @(negedge clk);
        idx = 1'b1;
        @(negedge clk);
        idx = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        total++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        // R8: start-up with both phases high, no count, no error
        do_reset(2'b11);
        chk("R8 pos", {24'b0, pos}, 32'd0);
        chk("R8 err", {31'b0, err}, 32'd0);
        chk("R8 step", {31'b0, stp}, 32'd0);

        // R1: nothing after two edges, count after the third
        @(negedge clk);
        {a, b} = 2'b01;
        repeat (2) @(posedge clk);
        #2;
        chk("R1 early", {24'b0, pos}, 32'd0);
        @(posedge clk);
        #2;
        chk("R1 due", {24'b0, pos}, 32'd1);

        // table walk from a fresh reset at 00
        do_reset(2'b00);
        foreach (VEC[i]) begin
            logic [4:0] v;
            string tag;
            v = VEC[i];
            tag = (i < 4) ? "R2" : (i < 8) ? "R3" : (i < 12) ? "R6" : (i < 16) ? "R4" : "R10";
            if (v[2]) ref_pos = v[1] ? ref_pos + 1'b1 : ref_pos - 1'b1;
            drive(v[4:3], tag, v[2], v[1]);
            chk(tag, {31'b0, err}, {31'b0, v[0]});
        end

        // R5: error held, then cleared by one-cycle pulse
        repeat (5) @(posedge clk);
        #2;
        chk("R5 held", {31'b0, err}, 32'd1);
        @(negedge clk);
        eclr = 1'b1;
        @(negedge clk);
        eclr = 1'b0;
        chk("R5 cleared", {31'b0, err}, 32'd0);

        // R7: first index zeroes, later ones ignored
        step_up("R7 pre");
        step_up("R7 pre");
        step_up("R7 pre");
        pulse_index();
        repeat (4) @(posedge clk);
        #2;
        chk("R7 first", {24'b0, pos}, 32'd0);
        ref_pos = '0;
        step_up("R7 post");
        step_up("R7 post");
        pulse_index();
        repeat (4) @(posedge clk);
        #2;
        chk("R7 second", {24'b0, pos}, 32'd2);

        // R9: climb to the top, wrap, step back
        while (ref_pos != 8'd127) step_up("R9 climb");
        chk("R9 top", {24'b0, pos}, 32'd127);
        step_up("R9 wrap");
        chk("R9 wrap", {24'b0, pos}, 32'd128);
        ref_pos = ref_pos - 1'b1;
        case (cur_ab)
            2'b00:   drive(2'b01, "R9 back", 1'b1, 1'b0);
            2'b01:   drive(2'b11, "R9 back", 1'b1, 1'b0);
            2'b11:   drive(2'b10, "R9 back", 1'b1, 1'b0);
            default: drive(2'b00, "R9 back", 1'b1, 1'b0);
        endcase
        chk("R9 back", {24'b0, pos}, 32'd127);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule